// File: doc/BRIEF.md
# Card memory and I/O decoder

This block is the purely combinational address decoder of a plug-in card that sits on a 20-bit address bus. The card carries 32k of RAM and 32k of ROM in one 64k window, and a small I/O block made of a control port and a UART with eight registers. The decoder produces an active-low chip select for each of these four devices. The card can move both the memory window and the I/O block with two straps, so that two such cards can share one bus.

The decoder also drives an active-low external-I/O line for a 4k sub-window at offsets $D000-$DFFF of the card window. While that line is active, the local ROM is held off so that bus I/O devices answer there instead. A window-disable bit from the control port switches this sub-window off, and the ROM then answers across its whole range. A bus I/O-page select input tells the decoder that the current cycle falls in the I/O page. The I/O selects respond only during such cycles, and the memory side stays silent during them.

Top module: `card_dec`

## Requirements
- R1: The memory window responds only when address bits [19:16] equal 4'h0 with `mem_strap_i`=0, or 4'h3 with `mem_strap_i`=1. Any other top nibble leaves `ram_cs_no`, `rom_cs_no` and `ext_io_no` high.
- R2: Inside the window, offsets $0000-$7FFF (address bit 15 = 0) drive `ram_cs_no` low.
- R3: Inside the window, offsets $8000-$FFFF (bit 15 = 1) drive `rom_cs_no` low, except where R4 applies.
- R4: With `win_dis_i`=0, offsets $D000-$DFFF (bits [15:12] = 4'hD) drive `ext_io_no` low, and `rom_cs_no` stays high whenever `ext_io_no` is low.
- R5: With `win_dis_i`=1, `ext_io_no` stays high and the ROM answers at $D000-$DFFF.
- R6: With `io_page_ni`=0, address bits [11:4] equal to 8'hFE (`io_strap_i`=0) or 8'hFC (`io_strap_i`=1), and bit 3 = 0, `ctrl_cs_no` goes low. A prefix that does not match the strap selects nothing.
- R7: Under the same prefix and page conditions with bit 3 = 1, `uart_cs_no` goes low. Bits [2:0] pick the UART register and do not affect the decode.
- R8: The I/O selects are low only while `io_page_ni`=0. While `io_page_ni`=0, the RAM select, the ROM select and `ext_io_no` stay high.
- R9: At most one of `ram_cs_no`, `rom_cs_no`, `uart_cs_no`, `ctrl_cs_no` is low for any input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 20 | Bus address |
| mem_strap_i | input | 1 | Memory base strap: 0 → nibble 0, 1 → nibble 3 |
| io_strap_i | input | 1 | I/O prefix strap: 0 → $FE, 1 → $FC |
| win_dis_i | input | 1 | Control-port bit, 1 disables the external-I/O sub-window |
| io_page_ni | input | 1 | Bus I/O-page select, active low |
| ram_cs_no | output | 1 | RAM select, active low |
| rom_cs_no | output | 1 | ROM select, active low |
| uart_cs_no | output | 1 | UART select, active low |
| ctrl_cs_no | output | 1 | Control-port select, active low |
| ext_io_no | output | 1 | External-I/O bus line, active low |

## Verification
Every output is combinational, so each result is due in the same cycle as the inputs that cause it, with zero register stages. The driver applies a vector just after a rising edge and queues the expected select pattern. The monitor pops the queue and compares at the following falling edge, half a period later, when the logic has settled and before the next vector is applied. Assertions in the decoder check the exclusivity and suppression relations each time the outputs change.

// File: rtl/card_dec_pkg.sv
package card_dec_pkg;
  localparam int ADDR_W   = 20;
  localparam int WIN_W    = 16;
  localparam int PAGE_W   = 12;
  localparam int IO_REG_W = 3;
  localparam int N_IO_DEV = 2;

  typedef enum logic [0:0] {
    DEV_CTRL = 1'b0,
    DEV_UART = 1'b1
  } io_dev_e;

  typedef struct packed {
    logic ram;
    logic rom;
    logic ext;
  } mem_sel_t;
endpackage

// File: rtl/card_mem_dec.sv
module card_mem_dec
  import card_dec_pkg::*;
#(
  parameter int          AW         = ADDR_W,
  parameter int          WW         = WIN_W,
  parameter logic [3:0]  BASE_0     = 4'h0,
  parameter logic [3:0]  BASE_1     = 4'h3,
  parameter logic [3:0]  EXT_NIB    = 4'hD
) (
  input  logic [AW-1:0] addr_i,
  input  logic          strap_i,
  input  logic          win_dis_i,
  input  logic          mem_cycle_i,
  output mem_sel_t      sel_o
);
  localparam int NIB_W = AW - WW;

  logic [NIB_W-1:0] base;
  logic             base_hit;
  logic             in_sub;

  always_comb begin
    base     = strap_i ? NIB_W'(BASE_1) : NIB_W'(BASE_0);
    base_hit = mem_cycle_i && (addr_i[AW-1:WW] == base);
    in_sub   = (addr_i[WW-1:WW-4] == EXT_NIB);
    sel_o.ext = base_hit && in_sub && !win_dis_i;
    sel_o.ram = base_hit && !addr_i[WW-1];
    sel_o.rom = base_hit && addr_i[WW-1] && !sel_o.ext;
  end
endmodule

// File: rtl/card_io_dec.sv
module card_io_dec
  import card_dec_pkg::*;
#(
  parameter int          PW     = PAGE_W,
  parameter int          RW     = IO_REG_W,
  parameter int          NDEV   = N_IO_DEV,
  parameter logic [7:0]  PFX_0  = 8'hFE,
  parameter logic [7:0]  PFX_1  = 8'hFC
) (
  input  logic [PW-1:0]   page_addr_i,
  input  logic            strap_i,
  input  logic            io_cycle_i,
  output logic [NDEV-1:0] dev_hit_o
);
  localparam int DW   = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam int PFXW = PW - RW - DW;

  logic [PFXW-1:0] pfx;
  logic            pfx_hit;
  logic [DW-1:0]   dev_idx;

  always_comb begin
    pfx     = strap_i ? PFXW'(PFX_1) : PFXW'(PFX_0);
    pfx_hit = io_cycle_i && (page_addr_i[PW-1:RW+DW] == pfx);
    dev_idx = page_addr_i[RW+DW-1:RW];
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    assign dev_hit_o[d] = pfx_hit && (dev_idx == DW'(d));
  end
endmodule

// File: rtl/card_dec.sv
module card_dec
  import card_dec_pkg::*;
#(
  parameter int          AW      = ADDR_W,
  parameter logic [3:0]  BASE_0  = 4'h0,
  parameter logic [3:0]  BASE_1  = 4'h3,
  parameter logic [3:0]  EXT_NIB = 4'hD,
  parameter logic [7:0]  PFX_0   = 8'hFE,
  parameter logic [7:0]  PFX_1   = 8'hFC
) (
  input  logic [AW-1:0] addr_i,
  input  logic          mem_strap_i,
  input  logic          io_strap_i,
  input  logic          win_dis_i,
  input  logic          io_page_ni,
  output logic          ram_cs_no,
  output logic          rom_cs_no,
  output logic          uart_cs_no,
  output logic          ctrl_cs_no,
  output logic          ext_io_no
);
  mem_sel_t              mem_sel;
  logic [N_IO_DEV-1:0]   io_hit;

  card_mem_dec #(
    .AW(AW), .WW(WIN_W), .BASE_0(BASE_0), .BASE_1(BASE_1), .EXT_NIB(EXT_NIB)
  ) u_mem (
    .addr_i      (addr_i),
    .strap_i     (mem_strap_i),
    .win_dis_i   (win_dis_i),
    .mem_cycle_i (io_page_ni),
    .sel_o       (mem_sel)
  );

  card_io_dec #(
    .PW(PAGE_W), .RW(IO_REG_W), .NDEV(N_IO_DEV), .PFX_0(PFX_0), .PFX_1(PFX_1)
  ) u_io (
    .page_addr_i (addr_i[PAGE_W-1:0]),
    .strap_i     (io_strap_i),
    .io_cycle_i  (!io_page_ni),
    .dev_hit_o   (io_hit)
  );

  assign ram_cs_no  = !mem_sel.ram;
  assign rom_cs_no  = !mem_sel.rom;
  assign ext_io_no  = !mem_sel.ext;
  assign ctrl_cs_no = !io_hit[DEV_CTRL];
  assign uart_cs_no = !io_hit[DEV_UART];

  // Cross-module relations between the two decoders' outputs
  always_comb begin
    assert_sel_exclusive_R9: assert ($countones({~ram_cs_no, ~rom_cs_no,
                                                 ~uart_cs_no, ~ctrl_cs_no}) <= 1);
    assert_ext_blocks_rom_R4: assert (ext_io_no || rom_cs_no);
    assert_dis_quiet_R5: assert (!win_dis_i || ext_io_no);
    assert_io_page_only_R8: assert (!io_page_ni || (uart_cs_no && ctrl_cs_no));
    assert_mem_off_in_io_R8: assert (io_page_ni || (ram_cs_no && rom_cs_no && ext_io_no));
    assert_ext_in_sub_R4: assert (ext_io_no || (addr_i[WIN_W-1:WIN_W-4] == EXT_NIB));
  end
endmodule

// File: tb/card_dec_tb.sv
module card_dec_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] addr = '0;
  logic        mem_strap = 1'b0, io_strap = 1'b0, win_dis = 1'b0, io_page_n = 1'b1;
  logic        ram_cs_n, rom_cs_n, uart_cs_n, ctrl_cs_n, ext_io_n;

  always #2 clk = ~clk;  // 250 MHz

  card_dec u_dut (
    .addr_i(addr), .mem_strap_i(mem_strap), .io_strap_i(io_strap),
    .win_dis_i(win_dis), .io_page_ni(io_page_n),
    .ram_cs_no(ram_cs_n), .rom_cs_no(rom_cs_n), .uart_cs_no(uart_cs_n),
    .ctrl_cs_no(ctrl_cs_n), .ext_io_no(ext_io_n)
  );

  typedef struct {
    logic [4:0] exp;   // {ram,rom,uart,ctrl,ext}, active low
    string      tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_bad = 0;
  bit    done = 0;

  // Expected values straight from the requirements
  function automatic logic [4:0] model(logic [19:0] a, logic ms, logic is,
                                       logic wd, logic ipn);
    logic ram, rom, uart, ctrl, ext, inwin;
    logic [7:0] pfx;
    inwin = ipn && (a[19:16] == (ms ? 4'h3 : 4'h0));          // R1, R8
    ext   = inwin && a[15:12] == 4'hD && !wd;                   // R4, R5
    ram   = inwin && a[15] == 1'b0;                             // R2
    rom   = inwin && a[15] == 1'b1 && !ext;                     // R3
    pfx   = is ? 8'hFC : 8'hFE;
    ctrl  = !ipn && a[11:4] == pfx && !a[3];                    // R6
    uart  = !ipn && a[11:4] == pfx && a[3];                     // R7
    return {!ram, !rom, !uart, !ctrl, !ext};
  endfunction

  task automatic drive(logic [19:0] a, logic ms, logic is, logic wd,
                       logic ipn, string tag);
    item_t it;
    @(posedge clk);
    addr = a; mem_strap = ms; io_strap = is; win_dis = wd; io_page_n = ipn;
    it.exp = model(a, ms, is, wd, ipn);
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: combinational results are due half a period after the drive edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it  = q.pop_front();
      act = {ram_cs_n, rom_cs_n, uart_cs_n, ctrl_cs_n, ext_io_n};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s addr=%h act=%b exp=%b", it.tag, addr, act, it.exp);
      end
      if ($countones(~act[4:1]) > 1) begin
        n_bad++;
        $display("FAIL R9 addr=%h act=%b exp=at most one low", addr, act);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state after reset: nothing selected
    drive(20'hF0000, 0, 0, 0, 1, "reset_idle");

    for (int ms = 0; ms < 2; ms++) begin
      // R1: every top nibble, both halves of the window
      for (int n = 0; n < 16; n++) begin
        drive({n[3:0], 16'h1234}, ms[0], 0, 0, 1, "R1_ram_half");
        drive({n[3:0], 16'hA5A5}, ms[0], 0, 0, 1, "R1_rom_half");
      end
      // R2 RAM edges
      drive({ms[0] ? 4'h3 : 4'h0, 16'h0000}, ms[0], 0, 0, 1, "R2_low");
      drive({ms[0] ? 4'h3 : 4'h0, 16'h7FFF}, ms[0], 0, 0, 1, "R2_high");
      // R3 ROM edges and around the sub-window
      drive({ms[0] ? 4'h3 : 4'h0, 16'h8000}, ms[0], 0, 0, 1, "R3_low");
      drive({ms[0] ? 4'h3 : 4'h0, 16'hCFFF}, ms[0], 0, 0, 1, "R3_below_sub");
      drive({ms[0] ? 4'h3 : 4'h0, 16'hE000}, ms[0], 0, 0, 1, "R3_above_sub");
      drive({ms[0] ? 4'h3 : 4'h0, 16'hFFFF}, ms[0], 0, 0, 1, "R3_high");
      // R4 / R5 sub-window with enable and disable
      for (int wd = 0; wd < 2; wd++) begin
        drive({ms[0] ? 4'h3 : 4'h0, 16'hD000}, ms[0], 0, wd[0], 1,
              wd ? "R5_sub_low" : "R4_sub_low");
        drive({ms[0] ? 4'h3 : 4'h0, 16'hDFFF}, ms[0], 0, wd[0], 1,
              wd ? "R5_sub_high" : "R4_sub_high");
      end
      // R4: sub-window nibble in a non-matching base must stay quiet
      drive({ms[0] ? 4'h0 : 4'h3, 16'hD800}, ms[0], 0, 0, 1, "R4_wrong_base");
    end

    // R6 / R7 I/O page across straps, all register offsets
    for (int is = 0; is < 2; is++) begin
      for (int r = 0; r < 16; r++) begin
        drive({8'h00, is[0] ? 8'hFC : 8'hFE, r[3:0]}, 0, is[0], 0, 0,
              r < 8 ? "R6_ctrl" : "R7_uart");
      end
      // wrong prefix selects nothing
      drive({8'h00, is[0] ? 8'hFE : 8'hFC, 4'h0}, 0, is[0], 0, 0, "R6_wrong_pfx");
      drive({8'h00, is[0] ? 8'hFE : 8'hFC, 4'h8}, 0, is[0], 0, 0, "R7_wrong_pfx");
      drive({8'h00, 8'hFD, 4'h8}, 0, is[0], 0, 0, "R6_near_pfx");
    end

    // R8: I/O addresses without page select; memory addresses with it
    drive(20'h00FE0, 0, 0, 0, 1, "R8_ctrl_no_page");
    drive(20'h00FE8, 0, 0, 0, 1, "R8_uart_no_page");
    drive(20'h0D000, 0, 0, 0, 0, "R8_ext_in_page");
    drive(20'h08000, 0, 0, 0, 0, "R8_rom_in_page");
    drive(20'h3D000, 1, 0, 0, 0, "R8_ext_in_page_b3");
    drive(20'h0DFE0, 0, 0, 0, 0, "R8_overlap_ctrl");
    drive(20'h0DFE8, 0, 0, 1, 1, "R9_overlap_mem");

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule